// File: doc/BRIEF.md
# Quadrature and Pulse-Direction Decoder

This block sits in front of a position counter and converts two encoder lines, A and B, into a one-cycle count strobe and an up/down flag. The counter adds or subtracts on each strobe. Both encoder lines are asynchronous to the block clock. Each line passes through a flop synchroniser, and the block then compares the synchronised pair with the pair it held one cycle earlier.

A packed mode field selects one of four counting functions:
- pulse-direction, where A carries the pulses and B carries the direction;
- quadrature with one count per full cycle of A;
- quadrature with two counts per cycle (both edges of A);
- quadrature with four counts per cycle (every edge of A and B).

The same field also holds count-mode bits that belong to the downstream counter, and this block ignores them.

In the quadrature functions, a jump in which both lines change in one sample cannot come from a real encoder. Such a jump sets a sticky noise-error flag, and a separate clear input resets that flag. A single enable gates all counting and all error detection.

Top module: `qdec_top`

## Requirements
- R1: While `rst` is high and after it is released, `cnt_stb` is 0, `up_dn` is 1 and `noise_err` is 0 until an input edge is decoded.
- R2: `mode_in[4:3]` selects the function: 00 pulse-direction, 01 one-edge quadrature, 10 two-edge quadrature, 11 four-edge quadrature. `mode_in[2:0]` has no effect on any output.
- R3: In pulse-direction mode, only a rising edge of A gives a strobe. `up_dn` then takes the level of B (1 means up).
- R4: In one-edge quadrature mode, a rising A edge gives a strobe when the move is up, and a falling A edge gives a strobe when the move is down. No other edge gives a strobe.
- R5: In two-edge quadrature mode, every single-line change of A gives a strobe, and changes of B alone give none.
- R6: In four-edge quadrature mode, every single-line change of A or B gives a strobe. In all quadrature modes the move is up when {A,B} steps 00→01→11→10→00, and down when it steps the opposite way.
- R7: In a quadrature mode, a change of both A and B within one sample sets `noise_err` and gives no strobe. In pulse-direction mode, the same change never sets `noise_err`.
- R8: `noise_err` stays set until a cycle in which `err_clr` is high and no new error is detected. A new error in the same cycle as a clear wins.
- R9: While `ab_en` is 0, no strobe is produced, `noise_err` is not set and `up_dn` holds. The edge history keeps tracking, so re-enabling gives no spurious count.
- R10: An input change applied before clock edge k appears on `cnt_stb` and `up_dn` after edge k+2, and `cnt_stb` lasts one cycle.
- R11: `up_dn` changes only in a cycle in which `cnt_stb` is 1, and it reflects the last counted move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Encoder line A, asynchronous |
| b_in | input | 1 | Encoder line B, asynchronous |
| ab_en | input | 1 | Counting enable |
| mode_in | input | MODE_W (5) | Packed mode field; [4:3] is the function, [2:0] is ignored |
| err_clr | input | 1 | Clears the noise-error flag |
| cnt_stb | output | 1 | One-cycle count strobe |
| up_dn | output | 1 | Direction of the last counted move, 1 = up |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench targets four weak spots:
- **One-edge mode at the turnaround.** A design that counted rising A edges regardless of direction would miss every backward count, or count twice after a reversal.
- **Double-line jumps.** A decoder that treated a jump as two steps would emit a strobe and flip direction instead of flagging noise. The same jump in pulse-direction mode must raise no error.
- **Error set and clear in the same cycle.** A design that let the clear win would silently lose an error.
- **Disabled periods.** A design that froze its edge history while disabled would emit a spurious strobe when re-enabled.

A randomised walk then varies the function, the ignored mode bits, the enable and the clear from cycle to cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  // Function select values, decoded from the upper mode bits.
  typedef enum logic [1:0] {
    FN_PULSE = 2'b00,
    FN_QX1   = 2'b01,
    FN_QX2   = 2'b10,
    FN_QX4   = 2'b11
  } qdec_fn_e;

  typedef struct packed {
    logic a;
    logic b;
  } ab_pair_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  ab_pair_t cur,
  input  ab_pair_t prev,
  input  qdec_fn_e fn,
  output logic     step,
  output logic     dir_up,
  output logic     illegal
);
  logic a_chg, b_chg, a_rise, lines_eq, quad_up;

  always_comb begin
    a_chg    = cur.a ^ prev.a;
    b_chg    = cur.b ^ prev.b;
    a_rise   = cur.a & ~prev.a;
    lines_eq = ~(cur.a ^ cur.b);
    // A moving to match B, or B moving away from A, is an up step.
    quad_up  = a_chg ? lines_eq : ~lines_eq;

    step    = 1'b0;
    dir_up  = quad_up;
    illegal = 1'b0;
    unique case (fn)
      FN_PULSE: begin
        step   = a_rise;
        dir_up = cur.b;
      end
      FN_QX1: begin
        illegal = a_chg & b_chg;
        step    = a_chg & ~b_chg & ~(cur.a ^ quad_up);
      end
      FN_QX2: begin
        illegal = a_chg & b_chg;
        step    = a_chg & ~b_chg;
      end
      FN_QX4: begin
        illegal = a_chg & b_chg;
        step    = a_chg ^ b_chg;
      end
      default: step = 1'b0;
    endcase
  end
endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int MODE_W      = 5,
  parameter int FN_LSB      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_in,
  input  logic              b_in,
  input  logic              ab_en,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              err_clr,
  output logic              cnt_stb,
  output logic              up_dn,
  output logic              noise_err
);
  localparam int FN_W = 2;
  localparam int FN_MSB = FN_LSB + FN_W - 1;

  logic [1:0] raw_ab, sync_ab;
  ab_pair_t   cur_ab, prev_ab;
  qdec_fn_e   fn_sel;
  logic       dec_step, dec_up, dec_bad;

  assign raw_ab = {a_in, b_in};

  qdec_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in (raw_ab),
    .d_out(sync_ab)
  );

  assign cur_ab = ab_pair_t'(sync_ab);
  assign fn_sel = qdec_fn_e'(mode_in[FN_MSB:FN_LSB]);

  // History tracks even while disabled so re-enable is glitch free.
  always_ff @(posedge clk) begin
    if (rst) prev_ab <= '0;
    else     prev_ab <= cur_ab;
  end

  qdec_decode u_dec (
    .cur    (cur_ab),
    .prev   (prev_ab),
    .fn     (fn_sel),
    .step   (dec_step),
    .dir_up (dec_up),
    .illegal(dec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_stb   <= 1'b0;
      up_dn     <= 1'b1;
      noise_err <= 1'b0;
    end else begin
      cnt_stb <= ab_en & dec_step;
      if (ab_en & dec_step) up_dn <= dec_up;
      if (ab_en & dec_bad)  noise_err <= 1'b1;
      else if (err_clr)     noise_err <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_chk.sv
module qdec_chk (
  input logic clk,
  input logic rst,
  input logic ab_en,
  input logic err_clr,
  input logic cnt_stb,
  input logic up_dn,
  input logic noise_err
);
  // R9: strobes only follow an enabled decode cycle
  a_r9_stb_gated: assert property (@(posedge clk) disable iff (rst)
    cnt_stb |-> $past(ab_en));

  // R9: errors are only raised while enabled
  a_r9_err_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_err) |-> $past(ab_en));

  // R7: an illegal jump never counts
  a_r7_err_no_count: assert property (@(posedge clk) disable iff (rst)
    $rose(noise_err) |-> !cnt_stb);

  // R8: flag is sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past(noise_err) && !$past(err_clr)) |-> noise_err);

  // R8: a clear while disabled always empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(err_clr) && !$past(ab_en)) |-> !noise_err);

  // R11: direction only moves with a strobe
  a_r11_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !cnt_stb |-> (up_dn == $past(up_dn)));
endmodule

bind qdec_top qdec_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ab_en    (ab_en),
  .err_clr  (err_clr),
  .cnt_stb  (cnt_stb),
  .up_dn    (up_dn),
  .noise_err(noise_err)
);

// File: tb/qdec_top_tb.sv
module qdec_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_in = 1'b0, b_in = 1'b0, ab_en = 1'b0, err_clr = 1'b0;
  logic [4:0] mode_in = 5'd0;
  logic cnt_stb, up_dn, noise_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";
  int gpos = 0;

  always #10 clk = ~clk;

  qdec_top u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .ab_en(ab_en),
    .mode_in(mode_in), .err_clr(err_clr),
    .cnt_stb(cnt_stb), .up_dn(up_dn), .noise_err(noise_err)
  );

  // ---------------- reference model ----------------
  bit qa[$], qb[$];
  bit pa, pb;
  bit e_stb, e_up, e_err;

  function automatic int pos_of(bit a, bit b);
    if (!a && !b) return 0;
    if (!a && b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qa = {0, 0}; qb = {0, 0};
      pa = 0; pb = 0;
      e_stb = 0; e_up = 1; e_err = 0;
    end else begin
      bit ca, cb, set_err;
      int fn, d;
      ca = qa[0]; cb = qb[0];
      fn = mode_in[4:3];
      set_err = 0;
      e_stb = 0;
      if (ab_en) begin
        if (fn == 0) begin
          if (ca && !pa) begin e_stb = 1; e_up = cb; end
        end else begin
          d = (pos_of(ca, cb) - pos_of(pa, pb) + 4) % 4;
          if (d == 2) set_err = 1;
          else if (d != 0) begin
            bit up, hit;
            up = (d == 1);
            hit = (fn == 3) ||
                  ((ca != pa) && (fn == 2 || (fn == 1 && (ca == up))));
            if (hit) begin e_stb = 1; e_up = up; end
          end
        end
      end
      if (set_err) e_err = 1;
      else if (err_clr) e_err = 0;
      pa = ca; pb = cb;
      void'(qa.pop_front()); qa.push_back(a_in);
      void'(qb.pop_front()); qb.push_back(b_in);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (rst) begin
        if (cnt_stb !== 0 || up_dn !== 1 || noise_err !== 0) begin
          fails++;
          $display("FAIL R1 in reset: stb/up/err got %b%b%b expected 010",
                   cnt_stb, up_dn, noise_err);
        end
      end else if (cnt_stb !== e_stb || up_dn !== e_up || noise_err !== e_err) begin
        fails++;
        $display("FAIL %s R10 t=%0t: stb/up/err got %b%b%b expected %b%b%b",
                 tag, $time, cnt_stb, up_dn, noise_err, e_stb, e_up, e_err);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drv(bit a, bit b, int n);
    a_in = a; b_in = b;
    gpos = pos_of(a, b);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_pos(int p, int n);
    case (p % 4)
      0: drv(0, 0, n);
      1: drv(0, 1, n);
      2: drv(1, 1, n);
      default: drv(1, 0, n);
    endcase
  endtask

  task automatic walk(int steps, bit fwd, int n);
    for (int i = 0; i < steps; i++) go_pos(fwd ? gpos + 1 : gpos + 3, n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    ab_en = 1;
    tag = "R1";
    repeat (4) @(negedge clk);

    // R3 pulse-direction, both direction levels
    tag = "R3"; mode_in = 5'b00_000;
    drv(0, 1, 3); drv(1, 1, 3); drv(0, 1, 3); drv(1, 1, 3);
    drv(0, 0, 3); drv(1, 0, 3); drv(0, 0, 1); drv(1, 0, 1); drv(0, 0, 3);

    // R4 one-edge quadrature, forward then backward
    tag = "R4"; mode_in = 5'b01_000;
    walk(9, 1, 2); walk(9, 0, 2); walk(3, 1, 1); walk(3, 0, 1);

    // R5 two-edge quadrature
    tag = "R5"; mode_in = 5'b10_110;
    walk(8, 1, 2); walk(8, 0, 1);

    // R6 four-edge quadrature
    tag = "R6"; mode_in = 5'b11_001;
    walk(8, 1, 1); walk(8, 0, 2);

    // R7 double change: no error in pulse mode, error in quadrature
    tag = "R7"; mode_in = 5'b00_000;
    go_pos(0, 3); go_pos(2, 3); go_pos(0, 3);
    mode_in = 5'b11_000;
    go_pos(2, 4); walk(2, 1, 2);

    // R8 clear, then error arriving under a held clear
    tag = "R8";
    err_clr = 1; @(negedge clk); err_clr = 0; repeat (3) @(negedge clk);
    mode_in = 5'b01_000;
    err_clr = 1; go_pos(gpos + 2, 4); err_clr = 0;
    go_pos(gpos + 2, 3);
    repeat (3) @(negedge clk);

    // R9 disabled: walking and illegal jumps ignored, clean re-enable
    tag = "R9"; mode_in = 5'b11_000;
    err_clr = 1; @(negedge clk); err_clr = 0;
    ab_en = 0;
    walk(5, 0, 2); go_pos(gpos + 2, 2); walk(3, 1, 1);
    ab_en = 1; repeat (4) @(negedge clk);
    walk(3, 1, 2);

    // R2 R11 randomised walk over functions, ignored bits, enable, clear
    tag = "R2 R11";
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) mode_in[4:3] = 2'($urandom % 4);
      mode_in[2:0] = 3'($urandom);
      ab_en   = ($urandom % 8) != 0;
      err_clr = ($urandom % 6) == 0;
      go_pos(gpos + int'($urandom % 4), 1 + int'($urandom % 3));
    end
    err_clr = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule